// File: doc/BRIEF.md
# Two-Segment Processor Core with One Jump Delay Slot

This block is a very small instruction processor split into two pipeline segments. The fetch segment presents the program counter to an external instruction ROM every clock and latches the returned word. The execute segment decodes that word in the following clock. There are four operations: no-operation, increment a register, load an immediate into a register, and an unconditional absolute jump. The register file holds the program's variables.

A jump never flushes the pipeline. While execute is decoding a jump, fetch is already capturing the next sequential word, called the delay slot. That word always executes, and control reaches the target only after it. A compiler can put a no-operation in the slot and keep the program's meaning. It can also move a useful instruction into the slot, which gives the same results in one clock less per jump. Internal activity is visible through an execute-stage trace (valid flag and address) and a register write port.

Top module: `slot_pipe`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, `romAddr` is 0, `execValid` is 0 and `wrEn` is 0. All registers clear to 0, so execute holds a bubble and the first fetch is from address 0.
- R2: With no jump executing, `romAddr` advances by exactly 1 each clock (modulo 2^ADDR_W).
- R3: The word fetched from address A in one clock executes in the next clock, with `execValid`=1 and `execPc`=A.
- R4: Instruction word layout is [15:12] opcode, [11:8] register index, [7:0] immediate/address. LOAD (opcode 2) drives `wrEn`=1, `wrIdx`=register field and `wrData`=immediate.
- R5: INC (opcode 1) drives `wrEn`=1 and `wrData` = old register value + 1, wrapping from 255 to 0.
- R6: For JMP (opcode 3), the word at the jump's address + 1 always executes next, and the word at the target executes after it.
- R7: In the clock after a JMP executes, `romAddr` equals the jump's 8-bit target field.
- R8: A JMP sitting in a delay slot executes normally. Its own delay slot is the word at the first jump's target, and execution then continues at its own target.
- R9: NOP (opcode 0) and the unused opcodes 4 to 15 write no register and do not redirect fetch.
- R10: A program with a NOP in a jump's delay slot and the same program with a useful instruction moved into the slot leave identical register values. The filled version reaches its end one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| romAddr | output | 8 | Instruction fetch address |
| romData | input | 16 | Instruction word returned for romAddr in the same clock |
| execValid | output | 1 | Execute segment holds a real instruction (not the reset bubble) |
| execPc | output | 8 | Address of the instruction in execute |
| wrEn | output | 1 | Register write this clock |
| wrIdx | output | 4 | Register written |
| wrData | output | 8 | Value written |

## Verification
The bench builds the core with its default parameters: 8-bit addresses and data, and 16 registers. With 8-bit data, a load of 255 followed by an increment covers the wrap corner. With 16 registers, the 4-bit register field is used in full. Three programs run: one with a NOP-filled slot, the same program with an increment moved into the slot, and a chained jump-in-slot case containing an undefined opcode. A scoreboard compares every executed address and every register write in order, and then compares final register images and cycle counts between the first two programs.

// File: rtl/slot_pkg.sv
package slot_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_INC  = 4'd1,
    OP_LOAD = 4'd2,
    OP_JMP  = 4'd3
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPc;
    logic writeReg;
    logic takeImm;
  } ctrl_t;
endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
(
  input  logic       irValid,
  input  logic [3:0] opField,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    if (irValid) begin
      case (opcode_e'(opField))
        OP_INC:  ctl.writeReg = 1'b1;
        OP_LOAD: begin
          ctl.writeReg = 1'b1;
          ctl.takeImm  = 1'b1;
        end
        OP_JMP:  ctl.loadPc = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slot_dpath.sv
module slot_dpath
  import slot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_CNT = 16,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int INSTR_W = 4 + IDX_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctl,
  output logic [ADDR_W-1:0]  romAddr,
  input  logic [INSTR_W-1:0] romData,
  output logic               irValid,
  output logic [3:0]         opField,
  output logic [ADDR_W-1:0]  immField,
  output logic [ADDR_W-1:0]  execPc,
  output logic               wrEn,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [ADDR_W-1:0]  wrData
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [ADDR_W-1:0]  regs [REG_CNT];

  assign romAddr  = pc;
  assign opField  = ir[INSTR_W-1 -: 4];
  assign wrIdx    = ir[ADDR_W +: IDX_W];
  assign immField = ir[ADDR_W-1:0];

  // fetch segment: one word per clock, redirect when execute holds a jump
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      ir      <= '0;
      irValid <= 1'b0;
      execPc  <= '0;
    end else begin
      ir      <= romData;
      irValid <= 1'b1;
      execPc  <= pc;
      pc      <= ctl.loadPc ? immField : pc + ONE;
    end
  end

  // execute segment: register update
  assign wrEn   = ctl.writeReg;
  assign wrData = ctl.takeImm ? immField : regs[wrIdx] + ONE;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (wrEn && wrIdx == IDX_W'(g))
        regs[g] <= wrData;
    end
  end
endmodule

// File: rtl/slot_pipe.sv
module slot_pipe
  import slot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_CNT = 16,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int INSTR_W = 4 + IDX_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [ADDR_W-1:0]  romAddr,
  input  logic [INSTR_W-1:0] romData,
  output logic               execValid,
  output logic [ADDR_W-1:0]  execPc,
  output logic               wrEn,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [ADDR_W-1:0]  wrData
);
  ctrl_t             ctl;
  logic [3:0]        opField;
  logic [ADDR_W-1:0] immField;

  slot_ctrl u_ctrl (
    .irValid (execValid),
    .opField (opField),
    .ctl     (ctl)
  );

  slot_dpath #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .romAddr  (romAddr),
    .romData  (romData),
    .irValid  (execValid),
    .opField  (opField),
    .immField (immField),
    .execPc   (execPc),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData)
  );
endmodule

// File: rtl/slot_pipe_chk.sv
module slot_pipe_chk
  import slot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_CNT = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] romAddr,
  input logic              execValid,
  input logic [ADDR_W-1:0] execPc,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrData,
  input ctrl_t             ctl,
  input logic [3:0]        opField,
  input logic [ADDR_W-1:0] immField
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R1
  reset_bubble_chk: assert property (@(posedge clk)
    !rstN |=> (!execValid && romAddr == '0));

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadPc |=> romAddr == $past(romAddr) + ONE);

  // R3
  exec_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (execValid && execPc == $past(romAddr)));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadPc |=> romAddr == $past(immField));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && opField == OP_LOAD) |-> (wrEn && wrData == immField));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && opField != OP_LOAD && opField != OP_INC) |-> !wrEn);
endmodule

bind slot_pipe slot_pipe_chk #(.ADDR_W(ADDR_W), .REG_CNT(REG_CNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .romAddr   (romAddr),
  .execValid (execValid),
  .execPc    (execPc),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .ctl       (ctl),
  .opField   (opField),
  .immField  (immField)
);

// File: tb/slot_pipe_bench.sv
`timescale 1ns/1ps
module slot_pipe_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  romAddr;
  logic [15:0] romData;
  logic        execValid;
  logic [7:0]  execPc;
  logic        wrEn;
  logic [3:0]  wrIdx;
  logic [7:0]  wrData;

  logic [15:0] rom [256];
  assign romData = rom[romAddr];

  always #2.5 clk = ~clk; // 200 MHz

  slot_pipe u_slot_pipe (
    .clk(clk), .rstN(rstN), .romAddr(romAddr), .romData(romData),
    .execValid(execValid), .execPc(execPc),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  typedef struct {
    logic [7:0] pc;
    logic       wr;
    logic [3:0] idx;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t      q[$];
  int         checks = 0;
  int         errors = 0;
  int         cycleCnt = 0;
  int         doneCycle = 0;
  bit         tracking = 0;
  logic [7:0] obsReg [16];

  function automatic logic [15:0] mk(int op, int r, int imm);
    return {4'(op), 4'(r), 8'(imm)};
  endfunction

  task automatic pushExp(int pc, bit wr, int idx, int val, string tag);
    item_t it;
    it.pc = 8'(pc); it.wr = wr; it.idx = 4'(idx); it.val = 8'(val); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) cycleCnt++;

  // monitor: compares execute trace against the expected queue
  always @(negedge clk) begin
    if (rstN && wrEn) obsReg[wrIdx] = wrData;
    if (rstN && tracking && execValid && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      check(execPc == e.pc, e.tag, "execPc", execPc, e.pc);
      check(wrEn == e.wr, e.tag, "wrEn", wrEn, e.wr);
      if (e.wr) begin
        check(wrIdx == e.idx, e.tag, "wrIdx", wrIdx, e.idx);
        check(wrData == e.val, e.tag, "wrData", wrData, e.val);
      end
      if (q.size() == 0) begin
        doneCycle = cycleCnt;
        tracking = 0;
      end
    end
  end

  task automatic clearRom();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    for (int i = 0; i < 16; i++) obsReg[i] = 8'h00;
  endtask

  task automatic runProgram();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state at the ports
    check(romAddr == 8'd0, "R1", "romAddr", romAddr, 0);
    check(execValid == 1'b0, "R1", "execValid", execValid, 0);
    check(wrEn == 1'b0, "R1", "wrEn", wrEn, 0);
    cycleCnt = 0;
    tracking = 1;
    rstN = 1'b1;
    while (tracking) @(negedge clk);
  endtask

  int cycA, cycB;
  logic [7:0] finA [16];

  initial begin
    // Program A: NOP in delay slot
    clearRom();
    rom[0] = mk(2, 1, 5);   rom[1] = mk(2, 2, 0);  rom[2] = mk(1, 2, 0);
    rom[3] = mk(3, 0, 6);   rom[4] = mk(0, 0, 0);  rom[5] = mk(2, 1, 99);
    rom[6] = mk(1, 1, 0);   rom[7] = mk(3, 0, 7);  rom[8] = mk(0, 0, 0);
    pushExp(0, 1, 1, 5, "R4");
    pushExp(1, 1, 2, 0, "R4");
    pushExp(2, 1, 2, 1, "R5");
    pushExp(3, 0, 0, 0, "R9");
    pushExp(4, 0, 0, 0, "R6");
    pushExp(6, 1, 1, 6, "R7");
    pushExp(7, 0, 0, 0, "R6");
    fork
      runProgram();
      begin
        @(posedge rstN); @(negedge clk);
        // R2, R3: first fetch advanced, first word in execute
        check(romAddr == 8'd1, "R2", "romAddr", romAddr, 1);
        check(execValid && execPc == 8'd0, "R3", "execPc", execPc, 0);
      end
    join
    cycA = doneCycle;
    for (int i = 0; i < 16; i++) finA[i] = obsReg[i];

    // Program B: INC moved into delay slot
    clearRom();
    rom[0] = mk(2, 1, 5);   rom[1] = mk(2, 2, 0);  rom[2] = mk(3, 0, 5);
    rom[3] = mk(1, 2, 0);   rom[4] = mk(2, 1, 99); rom[5] = mk(1, 1, 0);
    rom[6] = mk(3, 0, 6);   rom[7] = mk(0, 0, 0);
    pushExp(0, 1, 1, 5, "R4");
    pushExp(1, 1, 2, 0, "R4");
    pushExp(2, 0, 0, 0, "R6");
    pushExp(3, 1, 2, 1, "R6");
    pushExp(5, 1, 1, 6, "R7");
    pushExp(6, 0, 0, 0, "R6");
    runProgram();
    cycB = doneCycle;
    // R10: same results, one clock earlier
    check(obsReg[1] == finA[1], "R10", "r1 final", obsReg[1], finA[1]);
    check(obsReg[2] == finA[2], "R10", "r2 final", obsReg[2], finA[2]);
    check(cycB + 1 == cycA, "R10", "cycles filled", cycB, cycA - 1);

    // Program C: jump in slot, wrap, undefined opcode
    clearRom();
    rom[0]  = mk(2, 3, 255); rom[1]  = mk(3, 0, 10); rom[2]  = mk(3, 0, 20);
    rom[3]  = mk(2, 3, 7);   rom[10] = mk(1, 3, 0);  rom[11] = mk(2, 3, 1);
    rom[20] = mk(15, 3, 42); rom[21] = mk(1, 3, 0);  rom[22] = mk(3, 0, 22);
    pushExp(0, 1, 3, 255, "R4");
    pushExp(1, 0, 0, 0, "R6");
    pushExp(2, 0, 0, 0, "R8");
    pushExp(10, 1, 3, 0, "R8");
    pushExp(20, 0, 0, 0, "R9");
    pushExp(21, 1, 3, 1, "R9");
    pushExp(22, 0, 0, 0, "R8");
    runProgram();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule